// File: doc/BRIEF.md
# Conditional Run Counter with Bit-Steered Flags

This block pairs a small three-state controller with a counter datapath. A one-cycle `start` pulse in idle opens a run. It zeroes the counter and clears the completion flag `flag_f`. From the next clock on, the counter steps up by one on every cycle. On each of those counting edges, two bits of the current count control the flags and the end of the run:

- The second-highest bit (A3) decides `flag_e`. If it is low, `flag_e` is cleared. If it is high, `flag_e` is set.
- When the top bit (A4) and the second-highest bit are both high, counting ends. The increment still happens on that edge.

One clock after counting ends, a dedicated state raises `flag_f` and returns the machine to idle. The outputs then hold until the next start.

The block is used as a self-timed sequence generator. Surrounding logic pulses `start` and then watches `busy` and `flag_f` to know when the run is over. It can also sample `count` and `flag_e` as progress markers along the way.

Top module: `cond_count_asm`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the controller in idle and forces `count` = 0, `flag_e` = 0, `flag_f` = 0 and `busy` = 0.
- R2: In idle with `start` low, a clock edge leaves `count`, `flag_e` and `flag_f` unchanged.
- R3: In idle with `start` high, the next edge sets `count` to 0, clears `flag_f`, leaves `flag_e` unchanged and raises `busy`.
- R4: In the counting state, every clock edge adds 1 to `count`.
- R5: In the counting state, each edge loads `flag_e` with bit CNT_W-2 of the count held before that edge. With the default width this is bit 2: 0 clears the flag and 1 sets it.
- R6: In the counting state, an edge where bits CNT_W-1 and CNT_W-2 are both 1 still increments `count` and moves to the flag-setting state. `busy` stays high for that one extra cycle.
- R7: The flag-setting state lasts exactly one edge. That edge sets `flag_f` to 1, drops `busy` and keeps `count` and `flag_e` unchanged.
- R8: `start` has no effect while `busy` is high.
- R9: With the default 4-bit width, a run from start covers 14 busy cycles and ends with `count` = 13, `flag_e` = 1 and `flag_f` = 1.
- R10: `flag_f` stays 0 in every cycle in which `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Opens a run when sampled high in idle |
| count | output | CNT_W | Counter value; the top bit is the MSB |
| flag_e | output | 1 | Flag steered by count bit CNT_W-2 |
| flag_f | output | 1 | Completion flag, set one clock after counting stops |
| busy | output | 1 | High while counting or setting the completion flag |

## Verification
The bound checker tests the per-edge rules on every cycle:
- the increment in the counting state;
- `flag_e` tracking the previous count's steering bit;
- the exit on both high bits, and the single-cycle flag-setting state;
- idle holding its values;
- the start transition and the reset state;
- `flag_f` staying low while busy.

Only the bench's scenarios can show properties of a whole run. These are the exact 14-cycle length and the final values, that a start pulse in the middle of a run is ignored, that `flag_e` is kept across a restart, and that a reset in the middle of a run aborts it cleanly.

// File: rtl/cca_pkg.sv
package cca_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_SETF  = 2'd2
    } cca_state_e;

    // control strobes from controller to datapath
    typedef struct packed {
        logic clr;    // zero counter, clear completion flag
        logic inc;    // step counter
        logic e_upd;  // load flag_e from steering bit
        logic f_set;  // raise completion flag
    } cca_ctl_t;

endpackage

// File: rtl/cca_ctrl.sv
module cca_ctrl
    import cca_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output cca_state_e       state,
    output cca_ctl_t         ctl,
    output logic             busy
);
    localparam int HI_BIT = CNT_W - 1;
    localparam int LO_BIT = CNT_W - 2;

    typedef struct packed {
        cca_state_e st;
    } ctrl_reg_t;

    ctrl_reg_t r_q, r_d;
    logic      stop_hit;

    assign stop_hit = count[HI_BIT] & count[LO_BIT];

    always_comb begin
        r_d       = r_q;
        ctl       = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl.clr = 1'b1;
                    r_d.st  = ST_COUNT;
                end
            end
            ST_COUNT: begin
                ctl.inc   = 1'b1;
                ctl.e_upd = 1'b1;
                if (stop_hit) begin
                    r_d.st = ST_SETF;
                end
            end
            ST_SETF: begin
                ctl.f_set = 1'b1;
                r_d.st    = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;
    assign busy  = (r_q.st != ST_IDLE);

endmodule

// File: rtl/cca_counter.sv
module cca_counter
    import cca_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cca_ctl_t         ctl,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_reg_t;

    cnt_reg_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (ctl.clr) begin
            c_d.val = '0;
        end else if (ctl.inc) begin
            c_d.val = c_q.val + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.val <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count = c_q.val;

endmodule

// File: rtl/cca_flags.sv
module cca_flags
    import cca_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cca_ctl_t         ctl,
    input  logic [CNT_W-1:0] count,
    output logic             flag_e,
    output logic             flag_f
);
    localparam int LO_BIT = CNT_W - 2;

    typedef struct packed {
        logic e;
        logic f;
    } flag_reg_t;

    flag_reg_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        if (ctl.clr) begin
            f_d.f = 1'b0;
        end
        if (ctl.e_upd) begin
            f_d.e = count[LO_BIT];
        end
        if (ctl.f_set) begin
            f_d.f = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign flag_e = f_q.e;
    assign flag_f = f_q.f;

endmodule

// File: rtl/cond_count_asm.sv
module cond_count_asm
    import cca_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [CNT_W-1:0] count,
    output logic             flag_e,
    output logic             flag_f,
    output logic             busy
);
    cca_ctl_t   ctl_w;
    cca_state_e state_w;

    cca_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .count (count),
        .state (state_w),
        .ctl   (ctl_w),
        .busy  (busy)
    );

    cca_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl_w),
        .count (count)
    );

    cca_flags #(.CNT_W(CNT_W)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl_w),
        .count  (count),
        .flag_e (flag_e),
        .flag_f (flag_f)
    );

endmodule

// File: rtl/cca_checker.sv
module cca_checker
    import cca_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] count,
    input logic             flag_e,
    input logic             flag_f,
    input logic             busy,
    input cca_state_e       state
);
    localparam int HI_BIT = CNT_W - 1;
    localparam int LO_BIT = CNT_W - 2;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (count == '0) && !flag_e && !flag_f && !busy);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> $stable(count) && $stable(flag_e) && $stable(flag_f));

    a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> busy && (count == '0) && !flag_f && $stable(flag_e));

    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT) |=> count == $past(count) + CNT_W'(1));

    a_r5_e_follows: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT) |=> flag_e == $past(count[LO_BIT]));

    a_r6_stop_exit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && count[HI_BIT] && count[LO_BIT]) |=> (state == ST_SETF) && busy);

    a_r7_setf_once: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETF) |=> (state == ST_IDLE) && flag_f && !busy && $stable(count) && $stable(flag_e));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && start && !(count[HI_BIT] && count[LO_BIT])) |=> (state == ST_COUNT));

    a_r10_f_low_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !flag_f);

endmodule

bind cond_count_asm cca_checker #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .count  (count),
    .flag_e (flag_e),
    .flag_f (flag_f),
    .busy   (busy),
    .state  (state_w)
);

// File: tb/cond_count_asm_bench.sv
module cond_count_asm_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int NVEC       = 17;
    localparam int WDOG       = 5000;

    // vector: {start, exp_count[3:0], exp_e, exp_f, exp_busy}
    localparam logic [7:0] VEC [NVEC] = '{
        {1'b0, 4'd0,  1'b0, 1'b0, 1'b0},  // idle hold
        {1'b1, 4'd0,  1'b0, 1'b0, 1'b1},  // start
        {1'b0, 4'd1,  1'b0, 1'b0, 1'b1},  // A=0 evaluated
        {1'b0, 4'd2,  1'b0, 1'b0, 1'b1},
        {1'b0, 4'd3,  1'b0, 1'b0, 1'b1},
        {1'b0, 4'd4,  1'b0, 1'b0, 1'b1},
        {1'b0, 4'd5,  1'b1, 1'b0, 1'b1},  // A=4: steering bit high
        {1'b1, 4'd6,  1'b1, 1'b0, 1'b1},  // start mid-run ignored
        {1'b0, 4'd7,  1'b1, 1'b0, 1'b1},
        {1'b0, 4'd8,  1'b1, 1'b0, 1'b1},
        {1'b0, 4'd9,  1'b0, 1'b0, 1'b1},  // A=8: steering bit low
        {1'b0, 4'd10, 1'b0, 1'b0, 1'b1},
        {1'b1, 4'd11, 1'b0, 1'b0, 1'b1},  // start ignored
        {1'b0, 4'd12, 1'b0, 1'b0, 1'b1},
        {1'b0, 4'd13, 1'b1, 1'b0, 1'b1},  // A=12: stop, go set F
        {1'b0, 4'd13, 1'b1, 1'b1, 1'b0},  // F set, idle
        {1'b0, 4'd13, 1'b1, 1'b1, 1'b0}   // idle hold
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] count;
    logic             flag_e, flag_f, busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    cond_count_asm #(.CNT_W(CNT_W)) u_cond_count_asm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .count  (count),
        .flag_e (flag_e),
        .flag_f (flag_f),
        .busy   (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_out(input string tag, input logic [3:0] c, input logic e,
                             input logic f, input logic b);
        n_checks++;
        if (count !== c || flag_e !== e || flag_f !== f || busy !== b) begin
            n_fail++;
            $display("FAIL %s: got count=%0d e=%0b f=%0b busy=%0b, expected count=%0d e=%0b f=%0b busy=%0b",
                     tag, count, flag_e, flag_f, busy, c, e, f, b);
        end
    endtask

    task automatic step(input logic s);
        @(negedge clk);
        start = s;
        @(posedge clk);
        #1;
    endtask

    function automatic string vec_tag(input int i);
        if (i == 0) return "R2";
        if (i == 1) return "R3";
        if (i == 7 || i == 12) return "R8";
        if (i == 6 || i == 10) return "R5";
        if (i == 14) return "R6";
        if (i == 15) return "R7";
        if (i == 16) return "R2";
        return "R4";
    endfunction

    initial begin
        for (int cyc = 0; cyc < WDOG; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int busy_cycles;
        // R1: reset state
        rst = 1'b1;
        step(1'b0);
        step(1'b0);
        @(negedge clk);
        rst = 1'b0;
        check_out("R1", 4'd0, 1'b0, 1'b0, 1'b0);

        // table walk: one full run
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][7]);
            check_out(vec_tag(i), VEC[i][6:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R3: restart keeps flag_e, clears count and flag_f
        step(1'b1);
        check_out("R3", 4'd0, 1'b1, 1'b0, 1'b1);

        // R9/R10: count busy cycles of this run (start edge already counted)
        busy_cycles = 1;
        while (busy && busy_cycles < 40) begin
            step(1'b0);
            if (busy) begin
                busy_cycles++;
                n_checks++;
                if (flag_f !== 1'b0) begin
                    n_fail++;
                    $display("FAIL R10: flag_f=%0b while busy, expected 0", flag_f);
                end
            end
        end
        n_checks++;
        if (busy_cycles != 14) begin
            n_fail++;
            $display("FAIL R9: busy cycles=%0d, expected 14", busy_cycles);
        end
        check_out("R9", 4'd13, 1'b1, 1'b1, 1'b0);

        // R1: reset in the middle of a run
        step(1'b1);
        step(1'b0);
        step(1'b0);
        step(1'b0);
        step(1'b0);
        step(1'b0);
        check_out("R5", 4'd5, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check_out("R1", 4'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R2: idle stays put over several cycles
        step(1'b0);
        step(1'b0);
        check_out("R2", 4'd0, 1'b0, 1'b0, 1'b0);

        // R8: start held high for a whole run still yields one run
        step(1'b1);
        for (int k = 0; k < 13; k++) step(1'b1);
        check_out("R8", 4'd13, 1'b1, 1'b0, 1'b1);
        step(1'b0);
        check_out("R7", 4'd13, 1'b1, 1'b1, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule